// File: doc/BRIEF.md
# Sequential Multiply, Divide and Shift Unit

This block is an iterating arithmetic helper for a 12-bit accumulator machine. It treats the accumulator (AC) and a second word, the multiplier-quotient register (MQ), as one 24-bit pair with AC as the upper half. It adds a one-bit link (L) and a step counter (SC). The host presents its current AC, MQ and L values with a command code and a 12-bit operand word, then pulses `start`. The unit copies everything in, works one bit position per clock and pulses `done` when its own AC, MQ, L and SC outputs hold the result. The host then copies those outputs back into its own registers.

Four command classes exist. Multiply and divide each run 12 shift-and-add or shift-and-subtract steps. Divide gives up early when the quotient cannot fit. Normalize shifts the pair left until the two top AC bits differ and counts the shifts. Three shifts move the pair by the operand plus one. Short register moves finish in a single cycle. A separate clear-AC input takes effect before the command acts, so clear can be paired with any command.

Top module: `xmd_unit`

## Requirements
- R1: Multiply (cmd 1) forms the unsigned product of MQ and the operand. The upper 12 bits go to AC, the lower 12 bits to MQ, and L is cleared. `done` is high 13 cycles after the start edge.
- R2: Divide (cmd 2) divides the 24-bit value AC:MQ by the operand when AC is less than the operand. It leaves the quotient in MQ, the remainder in AC and L at 0. `done` is high 13 cycles after start.
- R3: When divide finds AC greater than or equal to the operand (a zero divisor included), it stops after one iteration. L becomes 1, AC and MQ are unchanged, and `done` is high 2 cycles after start.
- R4: Normalize (cmd 3) shifts AC:MQ left with zero fill until AC bit 11 differs from AC bit 10, up to at most 24 shifts. SC ends holding the shift count. L ends holding the last bit shifted out of AC bit 11, or 0 if no shift occurred. `done` is high shifts+2 cycles after start.
- R5: Shift left (cmd 4) moves AC:MQ left operand+1 places with zeros entering MQ bit 0. L receives the last bit that leaves AC bit 11. `done` is high operand+2 cycles after start.
- R6: Arithmetic right shift (cmd 5) moves AC:MQ right operand+1 places, copying AC bit 11 into the vacated places. Logical right shift (cmd 6) does the same with zero fill. Bits leaving MQ bit 0 are lost, and L keeps the value it was given.
- R7: Load MQ (cmd 7) puts the AC value into MQ and zeroes AC, and `done` is high 1 cycle after start.
- R8: MQ-to-AC (cmd 8) and SC-to-AC (cmd 9) OR their source into AC. The clear input zeroes AC before the OR, so a clear paired with either command leaves exactly the source value.
- R9: SC is written only by normalize. Every other command leaves it unchanged.
- R10: `busy` stays high from the start edge of an iterating command until the cycle that `done` rises. `done` is a one-cycle pulse that is never high together with `busy`. A `start` while busy is ignored.
- R11: After reset, AC, MQ, L, SC, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; ignored while busy |
| cmd | input | 4 | Command code: 0 none, 1 multiply, 2 divide, 3 normalize, 4 shift left, 5 arithmetic right, 6 logical right, 7 load MQ, 8 MQ to AC, 9 SC to AC |
| clr_ac | input | 1 | Zero AC before the command acts |
| operand | input | W | Multiplicand, divisor or shift count |
| ac_in | input | W | Host accumulator value |
| mq_in | input | W | Host MQ value |
| link_in | input | 1 | Host link value |
| ac_out | output | W | Resulting AC |
| mq_out | output | W | Resulting MQ |
| link_out | output | 1 | Resulting L |
| sc_out | output | $clog2(2W+1) | Step counter |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result has a fixed due cycle counted from the edge that accepts `start`. Single-cycle moves are due 1 cycle later. Multiply and full divide are due 13 cycles later, an aborted divide 2 cycles later, normalize at shift count plus 2, and the shifts at operand plus 2. The driver computes this due cycle when it raises `start` and stores it in the scoreboard item. The monitor samples on the falling edge and compares the cycle at which `done` appears with the stored value. It then compares AC, MQ, L and SC. An extra `done` from an ignored start would find an empty queue and count as a failure.

// File: rtl/xmd_pkg.sv
package xmd_pkg;
  typedef enum logic [3:0] {
    XC_NOP  = 4'd0,
    XC_MUL  = 4'd1,
    XC_DIV  = 4'd2,
    XC_NORM = 4'd3,
    XC_SHL  = 4'd4,
    XC_ASR  = 4'd5,
    XC_LSR  = 4'd6,
    XC_LMQ  = 4'd7,
    XC_MQA  = 4'd8,
    XC_SCA  = 4'd9
  } xmd_cmd_e;
endpackage

// File: rtl/xmd_muldiv_step.sv
module xmd_muldiv_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] mul_ac,
  output logic [W-1:0] mul_mq,
  output logic [W-1:0] div_ac,
  output logic [W-1:0] div_mq,
  output logic         div_ovf
);
  logic [W:0] sum;
  logic [W:0] rem_sh;
  logic [W:0] rem_nx;
  logic       fits;
  logic       div_unused;

  // multiply: add multiplicand when the low multiplier bit is set, then shift right
  always_comb begin
    sum    = {1'b0, ac} + (mq[0] ? {1'b0, opnd} : '0);
    mul_ac = sum[W:1];
    mul_mq = {sum[0], mq[W-1:1]};
  end

  // restoring divide: shift remainder left, subtract when it fits
  always_comb begin
    rem_sh  = {ac, mq[W-1]};
    fits    = (rem_sh >= {1'b0, opnd});
    rem_nx  = fits ? (rem_sh - {1'b0, opnd}) : rem_sh;
    div_ac  = rem_nx[W-1:0];
    div_mq  = {mq[W-2:0], fits};
    div_ovf = (ac >= opnd);
  end

  assign div_unused = rem_nx[W];
endmodule

// File: rtl/xmd_shift_step.sv
module xmd_shift_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic         arith,
  output logic [W-1:0] shl_ac,
  output logic [W-1:0] shl_mq,
  output logic         shl_out,
  output logic [W-1:0] shr_ac,
  output logic [W-1:0] shr_mq,
  output logic         normd
);
  localparam int DW = 2 * W;
  logic [DW-1:0] pair;
  logic [DW-1:0] left;
  logic [DW-1:0] right;
  logic          fill;

  always_comb begin
    pair    = {ac, mq};
    left    = {pair[DW-2:0], 1'b0};
    fill    = arith & ac[W-1];
    right   = {fill, pair[DW-1:1]};
    shl_ac  = left[DW-1:W];
    shl_mq  = left[W-1:0];
    shl_out = ac[W-1];
    shr_ac  = right[DW-1:W];
    shr_mq  = right[W-1:0];
    normd   = ac[W-1] ^ ac[W-2];
  end
endmodule

// File: rtl/xmd_iter_ctrl.sv
module xmd_iter_ctrl #(
  parameter int CNTW = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_iter,
  input  logic [CNTW-1:0] load_count,
  input  logic            early_stop,
  output logic            busy,
  output logic            done
);
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        if (is_iter) begin
          busy <= 1'b1;
          cnt  <= load_count;
        end else begin
          done <= 1'b1;
        end
      end else if (busy) begin
        if (early_stop || cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - CNTW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/xmd_unit.sv
module xmd_unit
  import xmd_pkg::*;
#(
  parameter int W = 12,
  localparam int DW = 2 * W,
  localparam int SCW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [3:0]     cmd,
  input  logic           clr_ac,
  input  logic [W-1:0]   operand,
  input  logic [W-1:0]   ac_in,
  input  logic [W-1:0]   mq_in,
  input  logic           link_in,
  output logic [W-1:0]   ac_out,
  output logic [W-1:0]   mq_out,
  output logic           link_out,
  output logic [SCW-1:0] sc_out,
  output logic           busy,
  output logic           done
);
  localparam int CNTW = W + 1;

  xmd_cmd_e       cmd_in;
  xmd_cmd_e       cmd_q;
  logic [W-1:0]   ac_q, mq_q, op_q, ac_v;
  logic           l_q;
  logic [SCW-1:0] sc_q;
  logic           start_ok, is_iter, early_stop;
  logic [CNTW-1:0] load_count;

  logic [W-1:0] mul_ac, mul_mq, div_ac, div_mq;
  logic         div_ovf;
  logic [W-1:0] shl_ac, shl_mq, shr_ac, shr_mq;
  logic         shl_out, normd;

  assign cmd_in   = xmd_cmd_e'(cmd);
  assign start_ok = start && !busy;
  assign ac_v     = clr_ac ? '0 : ac_in;

  always_comb begin
    is_iter    = 1'b0;
    load_count = '0;
    case (cmd_in)
      XC_MUL, XC_DIV: begin
        is_iter    = 1'b1;
        load_count = CNTW'(W);
      end
      XC_NORM: begin
        is_iter    = 1'b1;
        load_count = CNTW'(DW + 1);
      end
      XC_SHL, XC_ASR, XC_LSR: begin
        is_iter    = 1'b1;
        load_count = {1'b0, operand} + CNTW'(1);
      end
      default: ;
    endcase
  end

  assign early_stop = busy && ((cmd_q == XC_DIV  && div_ovf) ||
                               (cmd_q == XC_NORM && normd));

  xmd_muldiv_step #(.W(W)) u_md (
    .ac(ac_q), .mq(mq_q), .opnd(op_q),
    .mul_ac(mul_ac), .mul_mq(mul_mq),
    .div_ac(div_ac), .div_mq(div_mq), .div_ovf(div_ovf)
  );

  xmd_shift_step #(.W(W)) u_sh (
    .ac(ac_q), .mq(mq_q), .arith(cmd_q == XC_ASR),
    .shl_ac(shl_ac), .shl_mq(shl_mq), .shl_out(shl_out),
    .shr_ac(shr_ac), .shr_mq(shr_mq), .normd(normd)
  );

  xmd_iter_ctrl #(.CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .is_iter(is_iter),
    .load_count(load_count), .early_stop(early_stop),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q  <= '0;
      mq_q  <= '0;
      l_q   <= 1'b0;
      sc_q  <= '0;
      op_q  <= '0;
      cmd_q <= XC_NOP;
    end else if (start_ok) begin
      cmd_q <= cmd_in;
      op_q  <= operand;
      ac_q  <= ac_v;
      mq_q  <= mq_in;
      l_q   <= link_in;
      case (cmd_in)
        XC_MUL: begin
          ac_q <= '0;
          l_q  <= 1'b0;
        end
        XC_NORM: begin
          sc_q <= '0;
          l_q  <= 1'b0;
        end
        XC_LMQ: begin
          mq_q <= ac_v;
          ac_q <= '0;
        end
        XC_MQA: ac_q <= ac_v | mq_in;
        XC_SCA: ac_q <= ac_v | {{(W-SCW){1'b0}}, sc_q};
        default: ;
      endcase
    end else if (busy) begin
      case (cmd_q)
        XC_MUL: begin
          ac_q <= mul_ac;
          mq_q <= mul_mq;
        end
        XC_DIV: begin
          if (div_ovf) begin
            l_q <= 1'b1;
          end else begin
            ac_q <= div_ac;
            mq_q <= div_mq;
            l_q  <= 1'b0;
          end
        end
        XC_NORM: begin
          if (!normd && sc_q != SCW'(DW)) begin
            ac_q <= shl_ac;
            mq_q <= shl_mq;
            l_q  <= shl_out;
            sc_q <= sc_q + SCW'(1);
          end
        end
        XC_SHL: begin
          ac_q <= shl_ac;
          mq_q <= shl_mq;
          l_q  <= shl_out;
        end
        XC_ASR, XC_LSR: begin
          ac_q <= shr_ac;
          mq_q <= shr_mq;
        end
        default: ;
      endcase
    end
  end

  assign ac_out   = ac_q;
  assign mq_out   = mq_q;
  assign link_out = l_q;
  assign sc_out   = sc_q;
endmodule

// File: rtl/xmd_unit_checker.sv
module xmd_unit_checker #(
  parameter int W = 12,
  localparam int DW = 2 * W,
  localparam int SCW = $clog2(DW + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic [SCW-1:0] sc_out,
  input logic [3:0]     cmd_q
);
  // R10: an iteration only ends through a done pulse
  assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R10: done and busy never overlap
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R10: the running command cannot be replaced while busy
  assert_cmd_held_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_q));

  // R4: normalize never counts past the pair width
  assert_sc_bound_R4: assert property (@(posedge clk) disable iff (rst)
    sc_out <= SCW'(DW));
endmodule

bind xmd_unit xmd_unit_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .sc_out(sc_out), .cmd_q(cmd_q)
);

// File: tb/xmd_unit_bench.sv
module xmd_unit_bench;
  localparam int W = 12;
  localparam int CLK_PERIOD = 10;
  localparam int SCW = $clog2(2 * W + 1);

  typedef struct {
    logic [W-1:0]   ac;
    logic [W-1:0]   mq;
    logic           l;
    logic [SCW-1:0] sc;
    int             due;
    string          req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] cmd = '0;
  logic clr_ac = 1'b0;
  logic [W-1:0] operand = '0, ac_in = '0, mq_in = '0;
  logic link_in = 1'b0;
  logic [W-1:0] ac_out, mq_out;
  logic link_out;
  logic [SCW-1:0] sc_out;
  logic busy, done;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int m_sc = 0;
  exp_t sb[$];

  xmd_unit #(.W(W)) u_xmd_unit (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .clr_ac(clr_ac),
    .operand(operand), .ac_in(ac_in), .mq_in(mq_in), .link_in(link_in),
    .ac_out(ac_out), .mq_out(mq_out), .link_out(link_out), .sc_out(sc_out),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare each result when done appears
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "ac", int'(ac_out), int'(e.ac));
        chk(e.req, "mq", int'(mq_out), int'(e.mq));
        chk(e.req, "link", int'(link_out), int'(e.l));
        chk({e.req, " R9"}, "sc", int'(sc_out), int'(e.sc));
        chk(e.req, "done cycle", cyc, e.due);
      end
    end
  end

  // driver: compute expectation, push it, pulse start, optionally intrude
  task automatic issue(input logic [3:0] c, input logic clr, input logic [W-1:0] a,
                       input logic [W-1:0] m, input logic l, input logic [W-1:0] op,
                       input string req, input bit intrude);
    exp_t e;
    logic [2*W-1:0] v;
    logic [W-1:0] av;
    int lat;
    av = clr ? '0 : a;
    e.ac = av; e.mq = m; e.l = l; lat = 1;
    case (c)
      4'd1: begin
        v = {{W{1'b0}}, m} * {{W{1'b0}}, op};
        e.ac = v[2*W-1:W]; e.mq = v[W-1:0]; e.l = 1'b0; lat = W + 1;
      end
      4'd2: begin
        if (av >= op) begin
          e.l = 1'b1; lat = 2;
        end else begin
          v = {av, m};
          e.mq = W'(v / {{W{1'b0}}, op});
          e.ac = W'(v % {{W{1'b0}}, op});
          e.l = 1'b0; lat = W + 1;
        end
      end
      4'd3: begin
        int n;
        v = {av, m}; n = 0; e.l = 1'b0;
        while (n < 2 * W && v[2*W-1] == v[2*W-2]) begin
          e.l = v[2*W-1]; v = v << 1; n++;
        end
        e.ac = v[2*W-1:W]; e.mq = v[W-1:0]; m_sc = n; lat = n + 2;
      end
      4'd4, 4'd5, 4'd6: begin
        v = {av, m};
        for (int i = 0; i <= int'(op); i++) begin
          if (c == 4'd4) begin
            e.l = v[2*W-1]; v = v << 1;
          end else begin
            v = {(c == 4'd5) ? v[2*W-1] : 1'b0, v[2*W-1:1]};
          end
        end
        e.ac = v[2*W-1:W]; e.mq = v[W-1:0]; lat = int'(op) + 2;
      end
      4'd7: begin e.mq = av; e.ac = '0; end
      4'd8: e.ac = av | m;
      4'd9: e.ac = av | W'(m_sc);
      default: ;
    endcase
    e.sc = SCW'(m_sc);
    e.req = req;
    @(negedge clk);
    e.due = cyc + lat;
    sb.push_back(e);
    start = 1'b1; cmd = c; clr_ac = clr; ac_in = a; mq_in = m; link_in = l; operand = op;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      chk("R10", "busy mid-run", int'(busy), 1);
      start = 1'b1; cmd = 4'd8; clr_ac = 1'b1; mq_in = 12'h5A5;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("R10", "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11", "ac", int'(ac_out), 0);
    chk("R11", "mq", int'(mq_out), 0);
    chk("R11", "link", int'(link_out), 0);
    chk("R11", "sc", int'(sc_out), 0);
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "done", int'(done), 0);

    issue(4'd1, 1'b0, 12'h123, 12'hFFF, 1'b1, 12'hFFF, "R1", 1'b0);
    issue(4'd1, 1'b0, 12'h000, 12'd123, 1'b0, 12'd45, "R1", 1'b0);
    issue(4'd2, 1'b0, 12'h012, 12'h345, 1'b1, 12'h100, "R2", 1'b0);
    issue(4'd2, 1'b0, 12'h7FE, 12'hFFF, 1'b0, 12'h7FF, "R2", 1'b0);
    issue(4'd2, 1'b0, 12'h200, 12'h321, 1'b0, 12'h100, "R3", 1'b0);
    issue(4'd2, 1'b0, 12'h000, 12'h321, 1'b0, 12'h000, "R3", 1'b0);
    issue(4'd3, 1'b0, 12'h000, 12'h001, 1'b1, 12'h000, "R4", 1'b0);
    issue(4'd9, 1'b1, 12'hF00, 12'h000, 1'b0, 12'h000, "R8", 1'b0);
    issue(4'd3, 1'b0, 12'h400, 12'h000, 1'b1, 12'h000, "R4", 1'b0);
    issue(4'd3, 1'b0, 12'h000, 12'h000, 1'b0, 12'h000, "R4", 1'b0);
    issue(4'd3, 1'b0, 12'hFFF, 12'hFFF, 1'b0, 12'h000, "R4", 1'b0);
    issue(4'd9, 1'b0, 12'h300, 12'h000, 1'b0, 12'h000, "R8", 1'b0);
    issue(4'd8, 1'b0, 12'h0F0, 12'h00F, 1'b1, 12'h000, "R8", 1'b0);
    issue(4'd8, 1'b1, 12'h0F0, 12'h00F, 1'b0, 12'h000, "R8", 1'b0);
    issue(4'd4, 1'b0, 12'hA05, 12'h801, 1'b0, 12'd3, "R5", 1'b0);
    issue(4'd4, 1'b0, 12'h000, 12'h801, 1'b0, 12'd12, "R5", 1'b0);
    issue(4'd5, 1'b0, 12'h9A0, 12'h0F3, 1'b1, 12'd4, "R6", 1'b0);
    issue(4'd6, 1'b0, 12'h9A0, 12'h0F3, 1'b1, 12'd4, "R6", 1'b0);
    issue(4'd5, 1'b0, 12'h800, 12'h000, 1'b0, 12'd30, "R6", 1'b0);
    issue(4'd7, 1'b0, 12'h6B2, 12'h111, 1'b1, 12'h000, "R7", 1'b0);
    issue(4'd6, 1'b0, 12'hFFF, 12'h000, 1'b0, 12'd20, "R10", 1'b1);
    issue(4'd0, 1'b1, 12'h777, 12'h222, 1'b1, 12'h000, "R8", 1'b0);

    repeat (3) @(negedge clk);
    chk("R10", "queue drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule